// File: doc/BRIEF.md
# Bipolar Line-Code Transmit Encoder

This block is the digital transmit path of one channel of a DS3/E3/STS-1 line interface. Terminal data enters on two rail inputs and leaves as two pulse-request outputs: `pulsePos` asks the line driver for a positive pulse and `pulseNeg` asks for a negative one. Both change once per bit period, on the falling edge of the transmit clock. The inputs are sampled on that same falling edge.

A four-bit control word selects the operating mode. In pass-through mode the two rails are assumed to be line-coded already and are copied straight to the outputs. In encoding mode only the positive rail is used, and it is read as plain binary data. Ones are sent with alternating polarity. Long runs of zeros are replaced by a substitution code that contains a deliberate polarity violation, so the line always carries enough transitions for the far end to recover the clock. The rate field chooses the code: three-zero substitution for the DS3 and STS-1 rates, four-zero substitution for the E3 rate.

Selecting single-rail input always turns the encoder on. Every path has the same latency of four bit periods. That buffer lets a substitution reach back and change zeros that have been accepted but not yet sent.

Top module: `bipolar_tx_encoder`

## Requirements
- R1: While `rstSync` is high at a falling clock edge, both outputs are 0 after that edge. After reset, the first mark is sent positive and the count of marks since the last violation starts at zero (even).
- R2: With `cfgCtrl[3]`=0 and `cfgCtrl[2]`=0 (dual-rail pass-through), a bit sampled on `posData`/`negData` at falling edge k appears unchanged on `pulsePos`/`pulseNeg` after falling edge k+4. When both rails are 1, both outputs are 1.
- R3: With `cfgCtrl[3]`=1 (single-rail), the block encodes `posData` whatever the value of `cfgCtrl[2]`, and `negData` has no effect on the outputs.
- R4: In encoding mode, each 1 that is not part of a substitution produces one pulse, with polarity opposite to the previous pulse (violations included). The first pulse after reset is positive.
- R5: For rate field `cfgCtrl[1:0]` = 00, 10 or 11, each run of three zeros becomes 00V if an odd number of marks has gone out since the last violation, and B0V if that number is even. B is a pulse that follows the alternation rule. V repeats the polarity of the previous pulse. A substitution resets the mark count.
- R6: For rate field 01, each run of four zeros becomes 000V when the mark count is odd and B00V when it is even, using the same B and V rules as R5.
- R7: With `cfgCtrl[3]`=0 and `cfgCtrl[2]`=1, the block encodes `posData` as in R4 to R6 and ignores `negData`.
- R8: In encoding mode, a bit sampled at falling edge k determines the outputs after falling edge k+4. This is the same latency as pass-through.
- R9: In encoding mode, the outputs never request both polarities at once, and never show more than three consecutive zero bit periods in the encoded stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| txClk | input | 1 | Transmit bit clock. All sampling and updates happen on its falling edge. |
| rstSync | input | 1 | Synchronous reset, active high. |
| cfgCtrl | input | 4 | Control word. [3] single-rail select, [2] encoder enable, [1:0] rate (00 DS3, 01 E3, 10 STS-1, 11 treated as three-zero code). |
| posData | input | 1 | Positive rail in pass-through mode; binary data in encoding mode. |
| negData | input | 1 | Negative rail in pass-through mode; ignored in encoding mode. |
| pulsePos | output | 1 | Request for a positive line pulse in this bit period. |
| pulseNeg | output | 1 | Request for a negative line pulse in this bit period. |

## Verification
The hardest case to reach from the ports is a substitution that reaches back into bits already buffered, with the choice between the B-form and the plain-V form resting on marks that are themselves still in the pipeline. This is most visible in the three-zero code, where two unsent bits before the window can change the parity. The bench reaches it by sweeping every 10-bit pattern from a fresh reset for each rate code, which places every mix of marks and zero runs at every offset from the window. It then runs long zero-biased pseudo-random streams, so that parity carries across many substitutions without a reset.

// File: rtl/linecode_pkg.sv
`timescale 1ns/1ps
package linecode_pkg;

  // Token held in each buffered bit slot of the encoder pipeline.
  typedef enum logic [2:0] {
    TK_IDLE   = 3'd0,  // slot holds no line data (after reset / in pass-through)
    TK_ZERO   = 3'd1,  // plain zero
    TK_MARK   = 3'd2,  // data one, alternating polarity
    TK_BPULSE = 3'd3,  // substitution balancing pulse, alternating polarity
    TK_VIOL   = 3'd4   // substitution violation, repeats last polarity
  } token_t;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic passThru;    // copy pre-coded rails
    logic useHdb3;     // four-zero substitution span
    logic substitute;  // incoming slot becomes a violation
    logic insertB;     // start of the window becomes a balancing pulse
  } tx_strobe_t;

  localparam int B3ZS_SPAN = 3;
  localparam int HDB3_SPAN = 4;

  // Parity of marks since the last violation, advanced by one token.
  function automatic logic advanceParity(input logic odd, input token_t t);
    case (t)
      TK_VIOL:             advanceParity = 1'b0;
      TK_MARK, TK_BPULSE:  advanceParity = ~odd;
      default:             advanceParity = odd;
    endcase
  endfunction

endpackage

// File: rtl/lc_tx_ctrl.sv
`timescale 1ns/1ps
module lc_tx_ctrl
  import linecode_pkg::*;
#(
  parameter int PIPE_DEPTH = 4
) (
  input  logic                        txClk,
  input  logic                        rstSync,
  input  logic [3:0]                  cfgCtrl,
  input  logic                        posData,
  input  token_t [PIPE_DEPTH-1:0]     pipeTok,
  output tx_strobe_t                  strobe
);

  localparam int LAST = PIPE_DEPTH - 1;

  logic singleRail, encEnable, encActive, hdb3Sel;
  logic parOdd, parBeforeWin, windowZero, runHit;
  int   winLen;

  assign singleRail = cfgCtrl[3];
  assign encEnable  = cfgCtrl[2];
  assign encActive  = singleRail | encEnable;     // single-rail forces the encoder on
  assign hdb3Sel    = (cfgCtrl[1:0] == 2'b01);
  assign winLen     = hdb3Sel ? HDB3_SPAN : B3ZS_SPAN;

  // Parity seen at the start of the zero window: output-side parity, advanced
  // by every buffered token that lies ahead of the window (oldest first).
  always_comb begin
    parBeforeWin = parOdd;
    for (int i = LAST; i >= 0; i--) begin
      if (i >= winLen - 1) parBeforeWin = advanceParity(parBeforeWin, pipeTok[i]);
    end
  end

  // The newest winLen-1 buffered slots plus the incoming bit must all be plain zeros.
  always_comb begin
    windowZero = 1'b1;
    for (int i = 0; i < PIPE_DEPTH; i++) begin
      if (i < winLen - 1 && pipeTok[i] != TK_ZERO) windowZero = 1'b0;
    end
  end

  assign runHit = encActive && !posData && windowZero;

  always_comb begin
    strobe.passThru   = ~encActive;
    strobe.useHdb3    = hdb3Sel;
    strobe.substitute = runHit;
    strobe.insertB    = runHit && !parBeforeWin;
  end

  // Output-side parity tracks the token leaving the buffer.
  always_ff @(negedge txClk) begin
    if (rstSync) parOdd <= 1'b0;
    else         parOdd <= advanceParity(parOdd, pipeTok[LAST]);
  end

  // R5/R6: a balancing pulse is only ever requested together with a violation
  p_b_with_v_r5: assert property (@(negedge txClk) disable iff (rstSync)
    strobe.insertB |-> strobe.substitute && !posData);

endmodule

// File: rtl/lc_tx_datapath.sv
`timescale 1ns/1ps
module lc_tx_datapath
  import linecode_pkg::*;
#(
  parameter int PIPE_DEPTH = 4
) (
  input  logic                        txClk,
  input  logic                        rstSync,
  input  logic                        posData,
  input  logic                        negData,
  input  tx_strobe_t                  strobe,
  output token_t [PIPE_DEPTH-1:0]     pipeTok,
  output logic                        pulsePos,
  output logic                        pulseNeg
);

  localparam int LAST = PIPE_DEPTH - 1;

  logic [PIPE_DEPTH-1:0] dualP, dualN;
  token_t                tokIn;
  logic                  lastPol;   // 1: previous pulse was positive
  logic                  encOut;
  logic [2:0]            zeroRun;

  always_comb begin
    if (strobe.passThru)        tokIn = TK_IDLE;
    else if (strobe.substitute) tokIn = TK_VIOL;
    else if (posData)           tokIn = TK_MARK;
    else                        tokIn = TK_ZERO;
  end

  // Token buffer; a balancing pulse overwrites the oldest slot of the window.
  always_ff @(negedge txClk) begin
    if (rstSync) begin
      for (int i = 0; i < PIPE_DEPTH; i++) pipeTok[i] <= TK_IDLE;
    end else begin
      pipeTok[0] <= tokIn;
      for (int i = 1; i < PIPE_DEPTH; i++) pipeTok[i] <= pipeTok[i-1];
      if (strobe.insertB) begin
        if (strobe.useHdb3) pipeTok[HDB3_SPAN-1] <= TK_BPULSE;
        else                pipeTok[B3ZS_SPAN-1] <= TK_BPULSE;
      end
    end
  end

  // Pass-through delay line for pre-coded rails.
  generate
    for (genvar g = 0; g < PIPE_DEPTH; g++) begin : g_dual
      always_ff @(negedge txClk) begin
        if (rstSync) begin
          dualP[g] <= 1'b0;
          dualN[g] <= 1'b0;
        end else if (g == 0) begin
          dualP[g] <= strobe.passThru & posData;
          dualN[g] <= strobe.passThru & negData;
        end else begin
          dualP[g] <= dualP[(g == 0) ? 0 : g-1];
          dualN[g] <= dualN[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  // Output stage: polarity assignment of the leaving token.
  always_ff @(negedge txClk) begin
    if (rstSync) begin
      pulsePos <= 1'b0;
      pulseNeg <= 1'b0;
      lastPol  <= 1'b0;
      encOut   <= 1'b0;
      zeroRun  <= '0;
    end else if (strobe.passThru) begin
      pulsePos <= dualP[LAST];
      pulseNeg <= dualN[LAST];
      encOut   <= 1'b0;
      zeroRun  <= '0;
    end else begin
      encOut <= 1'b1;
      case (pipeTok[LAST])
        TK_MARK, TK_BPULSE: begin
          pulsePos <= ~lastPol;
          pulseNeg <= lastPol;
          lastPol  <= ~lastPol;
          zeroRun  <= '0;
        end
        TK_VIOL: begin
          pulsePos <= lastPol;
          pulseNeg <= ~lastPol;
          zeroRun  <= '0;
        end
        TK_ZERO: begin
          pulsePos <= 1'b0;
          pulseNeg <= 1'b0;
          if (zeroRun != 3'd7) zeroRun <= zeroRun + 3'd1;
        end
        default: begin
          pulsePos <= 1'b0;
          pulseNeg <= 1'b0;
          zeroRun  <= '0;
        end
      endcase
    end
  end

  // R9: encoded output never asks for both polarities
  p_no_both_r9: assert property (@(negedge txClk) disable iff (rstSync)
    encOut |-> !(pulsePos && pulseNeg));

  // R9: the encoded line never carries more than three zeros in a row
  p_zero_limit_r9: assert property (@(negedge txClk) disable iff (rstSync)
    zeroRun <= 3'd3);

  // R5: a violation token leaving the buffer always becomes a line pulse
  p_viol_pulse_r5: assert property (@(negedge txClk) disable iff (rstSync)
    (!strobe.passThru && pipeTok[LAST] == TK_VIOL) |=> (pulsePos ^ pulseNeg));

endmodule

// File: rtl/bipolar_tx_encoder.sv
`timescale 1ns/1ps
module bipolar_tx_encoder
  import linecode_pkg::*;
#(
  parameter int PIPE_DEPTH = 4
) (
  input  logic       txClk,
  input  logic       rstSync,
  input  logic [3:0] cfgCtrl,
  input  logic       posData,
  input  logic       negData,
  output logic       pulsePos,
  output logic       pulseNeg
);

  tx_strobe_t              strobe;
  token_t [PIPE_DEPTH-1:0] pipeTok;

  lc_tx_ctrl #(.PIPE_DEPTH(PIPE_DEPTH)) u_ctrl (
    .txClk   (txClk),
    .rstSync (rstSync),
    .cfgCtrl (cfgCtrl),
    .posData (posData),
    .pipeTok (pipeTok),
    .strobe  (strobe)
  );

  lc_tx_datapath #(.PIPE_DEPTH(PIPE_DEPTH)) u_dp (
    .txClk    (txClk),
    .rstSync  (rstSync),
    .posData  (posData),
    .negData  (negData),
    .strobe   (strobe),
    .pipeTok  (pipeTok),
    .pulsePos (pulsePos),
    .pulseNeg (pulseNeg)
  );

  // Checker state: reset seen last edge, and length of the pass-through stretch.
  logic       rstQ;
  logic [2:0] passCnt;

  always_ff @(negedge txClk) begin
    rstQ <= rstSync;
    if (rstSync || cfgCtrl[3] || cfgCtrl[2]) passCnt <= '0;
    else if (passCnt != 3'd7)                passCnt <= passCnt + 3'd1;
  end

  // R1: outputs are cleared by reset
  p_reset_clear_r1: assert property (@(negedge txClk) disable iff (rstSync)
    rstQ |-> !pulsePos && !pulseNeg);

  // R2: steady pass-through copies both rails with a four-bit delay
  p_pass_delay_r2: assert property (@(negedge txClk) disable iff (rstSync)
    passCnt >= 3'd6 |-> pulsePos == $past(posData, 5) && pulseNeg == $past(negData, 5));

endmodule

// File: tb/bipolar_tx_encoder_tb.sv
`timescale 1ns/1ps
module bipolar_tx_encoder_tb;

  logic       txClk = 1'b0;
  logic       rstSync = 1'b1;
  logic [3:0] cfgCtrl = 4'b0000;
  logic       posData = 1'b0;
  logic       negData = 1'b0;
  logic       pulsePos, pulseNeg;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  bit inP [4096];
  bit inN [4096];
  bit expP[4096];
  bit expN[4096];
  int nBits;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 txClk = ~txClk;

  bipolar_tx_encoder u_dut (
    .txClk(txClk), .rstSync(rstSync), .cfgCtrl(cfgCtrl),
    .posData(posData), .negData(negData),
    .pulsePos(pulsePos), .pulseNeg(pulseNeg)
  );

  function automatic bit rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // Offline line-code model over the whole (zero-padded) stream.
  task automatic buildExpected(input bit encode, input bit hdb3);
    int run = 0;
    int span = hdb3 ? 4 : 3;
    bit odd = 1'b0;
    bit lastPos = 1'b0;
    for (int i = 0; i < nBits + 6; i++) begin
      if (!encode) begin
        expP[i] = inP[i];
        expN[i] = inN[i];
      end else begin
        expP[i] = 1'b0;
        expN[i] = 1'b0;
        if (inP[i]) begin
          lastPos = ~lastPos;
          expP[i] = lastPos;
          expN[i] = ~lastPos;
          odd = ~odd;
          run = 0;
        end else begin
          run++;
          if (run == span) begin
            if (!odd) begin
              lastPos = ~lastPos;
              expP[i-span+1] = lastPos;
              expN[i-span+1] = ~lastPos;
            end
            expP[i] = lastPos;
            expN[i] = ~lastPos;
            odd = 1'b0;
            run = 0;
          end
        end
      end
    end
  endtask

  task automatic checkBit(input string req, input int idx);
    checks++;
    if (pulsePos !== expP[idx] || pulseNeg !== expN[idx]) begin
      errors++;
      $display("FAIL %s cfg=%b bit %0d: got pos=%b neg=%b expected pos=%b neg=%b",
               req, cfgCtrl, idx, pulsePos, pulseNeg, expP[idx], expN[idx]);
    end
  endtask

  task automatic runStream(input logic [3:0] cfg, input bit encode, input bit hdb3,
                           input string req);
    for (int i = nBits; i < nBits + 6; i++) begin
      inP[i] = 1'b0;
      inN[i] = 1'b0;
    end
    buildExpected(encode, hdb3);
    // R1: reset with busy inputs leaves both outputs low
    @(posedge txClk); #1;
    rstSync = 1'b1; posData = 1'b1; negData = 1'b1; cfgCtrl = cfg;
    repeat (3) @(posedge txClk);
    #1;
    checks++;
    if (pulsePos !== 1'b0 || pulseNeg !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got pos=%b neg=%b expected pos=0 neg=0", pulsePos, pulseNeg);
    end
    rstSync = 1'b0;
    posData = inP[0];
    negData = inN[0];
    for (int j = 1; j <= nBits + 4; j++) begin
      @(posedge txClk); #1;
      if (j >= 5) checkBit(req, j - 5);
      posData = inP[j];
      negData = inN[j];
    end
  endtask

  initial begin
    // R5/R6/R3/R4/R8: every 10-bit pattern under each single-rail rate code
    for (int m = 0; m < 3; m++) begin
      logic [3:0] cfg;
      cfg = (m == 0) ? 4'b1000 : (m == 1) ? 4'b1001 : 4'b1010;
      for (int pat = 0; pat < 1024; pat++) begin
        nBits = 10;
        for (int b = 0; b < 10; b++) begin
          inP[b] = pat[b];
          inN[b] = ~pat[(b + 3) % 10];
        end
        runStream(cfg, 1'b1, (m == 1), (m == 1) ? "R6/R3/R4/R8" : "R5/R3/R4/R8");
      end
    end

    // R2: dual-rail pass-through, both rate codes, both-rails-high included
    for (int m = 0; m < 2; m++) begin
      nBits = 400;
      for (int b = 0; b < nBits; b++) begin
        inP[b] = rnd();
        inN[b] = rnd();
      end
      runStream((m == 0) ? 4'b0000 : 4'b0001, 1'b0, 1'b0, "R2");
    end

    // R7: dual-rail input with the encoder enabled; negative rail ignored
    for (int m = 0; m < 2; m++) begin
      nBits = 500;
      for (int b = 0; b < nBits; b++) begin
        inP[b] = rnd() & rnd();
        inN[b] = rnd();
      end
      runStream((m == 0) ? 4'b0100 : 4'b0101, 1'b1, (m == 1), "R7");
    end

    // R3: single-rail with the enable bit also set behaves the same
    nBits = 500;
    for (int b = 0; b < nBits; b++) begin
      inP[b] = rnd() & rnd();
      inN[b] = rnd();
    end
    runStream(4'b1101, 1'b1, 1'b1, "R3");

    // R5/R6: long zero-heavy streams, parity carried across many substitutions
    for (int m = 0; m < 3; m++) begin
      logic [3:0] cfg;
      cfg = (m == 0) ? 4'b1000 : (m == 1) ? 4'b1001 : 4'b1011;
      nBits = 3000;
      for (int b = 0; b < nBits; b++) begin
        inP[b] = rnd() & rnd() & rnd();
        inN[b] = rnd();
      end
      runStream(cfg, 1'b1, (m == 1), (m == 1) ? "R6" : "R5");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(190000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule